// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer arithmetic and logic unit of a 32-bit datapath in the classic two-operand style. Each cycle it may take an opcode, an operand size, a source operand, a destination operand and the current five-bit condition register. It returns the new destination value and the next condition register. The operations are:

- add, subtract, and add and subtract with the extend flag as carry-in;
- negate and negate with extend;
- compare;
- AND, OR, exclusive-OR and one's complement;
- clear, test and move;
- sign extension and half swap;
- add, subtract and compare on an address register.

Results and flags are registered. They appear one clock edge after a cycle with the enable high, and hold while the enable is low. Each operation class updates the flags by its own rule. The extend flag is a separate carry that arithmetic copies from the carry and that the other operations leave as it was. Operations below long size replace only the low byte or low half of the destination, and the bits above are passed through unchanged. Effective-address calculation, decimal arithmetic, multiply and divide belong to other blocks.

Top module: `int_alu_flags`

## Requirements
- R1: While `rst_n` is low, `result_o` and `flags_o` read 0. After a rising edge at which `en_i` is high, they show the outcome of the inputs sampled at that edge. After an edge at which `en_i` is low, they keep their previous values.
- R2: Flags are packed as bit 4 = X (extend), 3 = N, 2 = Z, 1 = V, 0 = C. Sizes are encoded 0 = byte (8), 1 = word (16), 2 or 3 = long (32). Opcode 0 computes dst+src, 1 computes dst-src, 2 computes dst+src+X and 3 computes dst-src-X. Each sets C to the carry or borrow out of the selected size, X equal to C, V to signed overflow, N to the top bit of the sized result and Z to whether the sized result is zero.
- R3: For opcodes 2 and 3, and for opcode 5, Z is cleared when the sized result is nonzero and otherwise keeps its incoming value.
- R4: Opcode 4 computes 0-dst and opcode 5 computes 0-dst-X. Both update all five flags by the rules of R2.
- R5: Opcode 6 (compare) evaluates dst-src at the selected size. It sets N, Z, V and C as for subtract, keeps X, and returns dst unchanged.
- R6: Opcodes 7 AND, 8 OR, 9 XOR, 10 one's complement of dst, 12 test (dst) and 13 move (src) set N and Z from the sized result, clear V and C, and keep X.
- R7: Opcode 11 writes zero into the sized field and produces N=0, Z=1, V=0 and C=0, with X kept.
- R8: For sized operations, bits of dst above the selected size appear unchanged in the result, and N is the top bit of the selected size.
- R9: Opcode 14 sign-extends dst. With size 0 or 1 it extends byte to word and keeps bits 31..16. With size 2 or 3 it extends word to long. N and Z are taken from the target width, V and C are cleared, and X is kept.
- R10: Opcode 15 exchanges the two 16-bit halves of dst. N and Z are taken from the 32-bit result, V and C are cleared, and X is kept.
- R11: Opcodes 16 (dst+src) and 17 (dst-src) work on the full 32 bits. With size 0 or 1, src is first sign-extended from its low 16 bits. All five flags are left unchanged.
- R12: Opcode 18 compares dst with src at 32 bits, using the same source extension as R11. It sets N, Z, V and C as for subtract, keeps X, and returns dst.
- R13: Opcodes 19 to 31 return dst and the incoming flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Capture enable for the operation on the inputs |
| op_i | input | 5 | Opcode |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| flags_i | input | 5 | Current flags {X,N,Z,V,C} |
| result_o | output | 32 | New destination value |
| flags_o | output | 5 | Next flags {X,N,Z,V,C} |

## Verification
Every result and flag set is due exactly one rising edge after the cycle that presents it with `en_i` high. The bench drives each operation on a falling edge and compares both outputs against its behavioural model on the next falling edge. A cycle with `en_i` low is checked on the following falling edge against the value expected before it. After `rst_n` rises, the internal reset needs two rising edges to release, so the bench waits three cycles before its first operation.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W   = 5;
  localparam int SIZE_W = 2;
  localparam int FLAG_W = 5;

  // flag bit positions
  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_LONG = 2'd2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_ADC  = 5'd2,
    OP_SBC  = 5'd3,
    OP_NEG  = 5'd4,
    OP_NEGC = 5'd5,
    OP_CMP  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_INV  = 5'd10,
    OP_CLR  = 5'd11,
    OP_TEST = 5'd12,
    OP_MOVE = 5'd13,
    OP_SEXT = 5'd14,
    OP_SWAP = 5'd15,
    OP_AADD = 5'd16,
    OP_ASUB = 5'd17,
    OP_ACMP = 5'd18
  } op_e;

endpackage

// File: rtl/alu_sizer.sv
module alu_sizer
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] value_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              msb_o,
  output logic              zero_o
);
  localparam int QW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        mask_o = {{(DATA_W-QW){1'b0}}, {QW{1'b1}}};
        msb_o  = value_i[QW-1];
      end
      SZ_WORD: begin
        mask_o = {{(DATA_W-HW){1'b0}}, {HW{1'b1}}};
        msb_o  = value_i[HW-1];
      end
      default: begin
        mask_o = {DATA_W{1'b1}};
        msb_o  = value_i[DATA_W-1];
      end
    endcase
    zero_o = ((value_i & mask_o) == '0);
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int QW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] a_m;
  logic [DATA_W-1:0] b_m;
  logic [DATA_W:0]   wide;
  logic              a_top;
  logic              b_top;
  logic              r_top;

  always_comb begin
    case (size_i)
      SZ_BYTE: mask = {{(DATA_W-QW){1'b0}}, {QW{1'b1}}};
      SZ_WORD: mask = {{(DATA_W-HW){1'b0}}, {HW{1'b1}}};
      default: mask = {DATA_W{1'b1}};
    endcase
    a_m = a_i & mask;
    b_m = b_i & mask;
    // masked operands: the bit just above the size is carry / borrow
    if (sub_i) wide = {1'b0, a_m} - {1'b0, b_m} - {{DATA_W{1'b0}}, cin_i};
    else       wide = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin_i};
    sum_o = wide[DATA_W-1:0] & mask;
    case (size_i)
      SZ_BYTE: begin
        carry_o = wide[QW];
        a_top = a_m[QW-1]; b_top = b_m[QW-1]; r_top = wide[QW-1];
      end
      SZ_WORD: begin
        carry_o = wide[HW];
        a_top = a_m[HW-1]; b_top = b_m[HW-1]; r_top = wide[HW-1];
      end
      default: begin
        carry_o = wide[DATA_W];
        a_top = a_m[DATA_W-1]; b_top = b_m[DATA_W-1]; r_top = wide[DATA_W-1];
      end
    endcase
    if (sub_i) ovf_o = (a_top != b_top) && (r_top != a_top);
    else       ovf_o = (a_top == b_top) && (r_top != a_top);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int QW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  always_comb begin
    case (op_i)
      OP_AND:  res_o = dst_i & src_i;
      OP_OR:   res_o = dst_i | src_i;
      OP_XOR:  res_o = dst_i ^ src_i;
      OP_INV:  res_o = ~dst_i;
      OP_CLR:  res_o = '0;
      OP_TEST: res_o = dst_i;
      OP_MOVE: res_o = src_i;
      OP_SEXT: begin
        if (size_i == SZ_BYTE || size_i == SZ_WORD)
          res_o = {{(DATA_W-QW){dst_i[QW-1]}}, dst_i[QW-1:0]};
        else
          res_o = {{(DATA_W-HW){dst_i[HW-1]}}, dst_i[HW-1:0]};
      end
      OP_SWAP: res_o = {dst_i[HW-1:0], dst_i[DATA_W-1:HW]};
      default: res_o = dst_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_rules.sv
module alu_flag_rules
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              msb_i,
  input  logic              zero_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_comb begin
    flags_o = flags_i;
    case (op_i)
      OP_ADD, OP_SUB, OP_NEG: begin
        flags_o[FX] = carry_i;
        flags_o[FN] = msb_i;
        flags_o[FZ] = zero_i;
        flags_o[FV] = ovf_i;
        flags_o[FC] = carry_i;
      end
      OP_ADC, OP_SBC, OP_NEGC: begin
        flags_o[FX] = carry_i;
        flags_o[FN] = msb_i;
        flags_o[FZ] = zero_i & flags_i[FZ];
        flags_o[FV] = ovf_i;
        flags_o[FC] = carry_i;
      end
      OP_CMP, OP_ACMP: begin
        flags_o[FN] = msb_i;
        flags_o[FZ] = zero_i;
        flags_o[FV] = ovf_i;
        flags_o[FC] = carry_i;
      end
      OP_AND, OP_OR, OP_XOR, OP_INV, OP_TEST, OP_MOVE, OP_SEXT, OP_SWAP: begin
        flags_o[FN] = msb_i;
        flags_o[FZ] = zero_i;
        flags_o[FV] = 1'b0;
        flags_o[FC] = 1'b0;
      end
      OP_CLR: begin
        flags_o[FN] = 1'b0;
        flags_o[FZ] = 1'b1;
        flags_o[FV] = 1'b0;
        flags_o[FC] = 1'b0;
      end
      default: flags_o = flags_i;
    endcase
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int HW = DATA_W / 2;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // operand steering
  logic [DATA_W-1:0] src_ext;
  logic [DATA_W-1:0] add_a;
  logic [DATA_W-1:0] add_b;
  logic              add_sub;
  logic              add_cin;
  logic              is_arith;
  logic [SIZE_W-1:0] eff_size;

  assign src_ext = (size_i == SZ_BYTE || size_i == SZ_WORD) ?
                   {{(DATA_W-HW){src_i[HW-1]}}, src_i[HW-1:0]} : src_i;

  always_comb begin
    add_a    = dst_i;
    add_b    = src_i;
    add_sub  = 1'b0;
    add_cin  = 1'b0;
    is_arith = 1'b1;
    eff_size = size_i;
    case (op_i)
      OP_ADD: ;
      OP_SUB, OP_CMP: add_sub = 1'b1;
      OP_ADC: add_cin = flags_i[FX];
      OP_SBC: begin
        add_sub = 1'b1;
        add_cin = flags_i[FX];
      end
      OP_NEG: begin
        add_a   = '0;
        add_b   = dst_i;
        add_sub = 1'b1;
      end
      OP_NEGC: begin
        add_a   = '0;
        add_b   = dst_i;
        add_sub = 1'b1;
        add_cin = flags_i[FX];
      end
      OP_AADD: begin
        add_b    = src_ext;
        eff_size = SZ_LONG;
      end
      OP_ASUB, OP_ACMP: begin
        add_b    = src_ext;
        add_sub  = 1'b1;
        eff_size = SZ_LONG;
      end
      OP_SEXT: begin
        is_arith = 1'b0;
        eff_size = (size_i == SZ_BYTE || size_i == SZ_WORD) ? SZ_WORD : SZ_LONG;
      end
      OP_SWAP: begin
        is_arith = 1'b0;
        eff_size = SZ_LONG;
      end
      default: is_arith = 1'b0;
    endcase
  end

  // datapath units
  logic [DATA_W-1:0] add_res;
  logic              add_carry;
  logic              add_ovf;
  logic [DATA_W-1:0] log_res;

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .size_i  (eff_size),
    .a_i     (add_a),
    .b_i     (add_b),
    .cin_i   (add_cin),
    .sub_i   (add_sub),
    .sum_o   (add_res),
    .carry_o (add_carry),
    .ovf_o   (add_ovf)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i   (op_i),
    .size_i (size_i),
    .src_i  (src_i),
    .dst_i  (dst_i),
    .res_o  (log_res)
  );

  logic [DATA_W-1:0] calc;
  logic [DATA_W-1:0] fld_mask;
  logic              calc_msb;
  logic              calc_zero;

  assign calc = is_arith ? add_res : log_res;

  alu_sizer #(.DATA_W(DATA_W)) u_sizer (
    .size_i  (eff_size),
    .value_i (calc),
    .mask_o  (fld_mask),
    .msb_o   (calc_msb),
    .zero_o  (calc_zero)
  );

  logic [FLAG_W-1:0] flags_nxt;

  alu_flag_rules u_flags (
    .op_i    (op_i),
    .flags_i (flags_i),
    .msb_i   (calc_msb),
    .zero_i  (calc_zero),
    .carry_i (add_carry),
    .ovf_i   (add_ovf),
    .flags_o (flags_nxt)
  );

  // result merge: compares discard the difference
  logic [DATA_W-1:0] result_nxt;

  always_comb begin
    if (op_i == OP_CMP || op_i == OP_ACMP) result_nxt = dst_i;
    else result_nxt = (dst_i & ~fld_mask) | (calc & fld_mask);
  end

  // output registers
  logic [DATA_W-1:0] result_q;
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (en_i) begin
      result_q <= result_nxt;
      flags_q  <= flags_nxt;
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;

endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [OP_W-1:0]   op_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic [FLAG_W-1:0] flags_o
);
  localparam int QW = DATA_W / 4;

  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(result_o) && $stable(flags_o));

  a_r2_extend_follows_carry: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (op_i <= OP_NEGC) |=> flags_o[FX] == flags_o[FC]);

  a_r3_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (op_i == OP_ADC || op_i == OP_SBC || op_i == OP_NEGC) && !flags_i[FZ]
    |=> !flags_o[FZ]);

  a_r5_compare_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && op_i == OP_CMP |=> result_o == $past(dst_i) && flags_o[FX] == $past(flags_i[FX]));

  a_r6_logic_clears_vc: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (op_i >= OP_AND) && (op_i <= OP_SWAP) |=> flags_o[FV:FC] == 2'b00);

  a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && op_i == OP_CLR |=> flags_o[FN:FC] == 4'b0100 && flags_o[FX] == $past(flags_i[FX]));

  a_r8_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (op_i <= OP_MOVE) && size_i == SZ_BYTE
    |=> result_o[DATA_W-1:QW] == $past(dst_i[DATA_W-1:QW]));

  a_r11_addr_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (op_i == OP_AADD || op_i == OP_ASUB) |=> flags_o == $past(flags_i));

  a_r12_addr_cmp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && op_i == OP_ACMP |=> result_o == $past(dst_i) && flags_o[FX] == $past(flags_i[FX]));

  a_r13_unused_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (op_i > OP_ACMP) |=> result_o == $past(dst_i) && flags_o == $past(flags_i));

endmodule

bind int_alu_flags int_alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .en_i     (en_i),
  .op_i     (op_i),
  .size_i   (size_i),
  .dst_i    (dst_i),
  .flags_i  (flags_i),
  .result_o (result_o),
  .flags_o  (flags_o)
);

// File: tb/int_alu_flags_tb_top.sv
module int_alu_flags_tb_top;

  logic        clk;
  logic        rst_n;
  logic        en_i;
  logic [4:0]  op_i;
  logic [1:0]  size_i;
  logic [31:0] src_i;
  logic [31:0] dst_i;
  logic [4:0]  flags_i;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int checks;
  int errors;
  bit done;
  logic [36:0] last_exp;

  int_alu_flags dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .src_i    (src_i),
    .dst_i    (dst_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .flags_o  (flags_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint as_signed(longint v, longint w);
    longint half = longint'(1) << (w - 1);
    return (v >= half) ? v - (longint'(1) << w) : v;
  endfunction

  // behavioural reference: returns {flags, result}
  function automatic logic [36:0] model(logic [4:0] op, logic [1:0] sz,
                                        logic [31:0] s, logic [31:0] d, logic [4:0] f);
    longint w, m, a, b, r, rm, sr, dl;
    bit cin, sub, carry, ovf, nn, zz;
    logic [4:0] nf;
    logic [31:0] res, bsrc;
    nf = f;
    res = d;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    dl = longint'(d);
    if (op <= 5'd6 || (op >= 5'd16 && op <= 5'd18)) begin
      bsrc = s;
      if (op >= 5'd16) begin
        w = 32;
        if (sz <= 2'd1) bsrc = {{16{s[15]}}, s[15:0]};
      end
      m = (longint'(1) << w) - 1;
      a = dl & m;
      b = longint'(bsrc) & m;
      cin = 1'b0;
      sub = (op != 5'd0 && op != 5'd2 && op != 5'd16);
      if (op == 5'd2 || op == 5'd3 || op == 5'd5) cin = f[4];
      if (op == 5'd4 || op == 5'd5) begin
        b = a;
        a = 0;
      end
      if (sub) begin
        r = a - b - longint'(cin);
        carry = (r < 0);
        sr = as_signed(a, w) - as_signed(b, w) - longint'(cin);
      end else begin
        r = a + b + longint'(cin);
        carry = (r > m);
        sr = as_signed(a, w) + as_signed(b, w) + longint'(cin);
      end
      ovf = (sr > (longint'(1) << (w - 1)) - 1) || (sr < -(longint'(1) << (w - 1)));
      rm = r & m;
      nn = ((rm >> (w - 1)) & 1) != 0;
      zz = (rm == 0);
      if (op <= 5'd5) begin
        nf = {carry, nn, (op == 5'd2 || op == 5'd3 || op == 5'd5) ? (zz & f[2]) : zz, ovf, carry};
        res = 32'((dl & ~m) | rm);
      end else if (op == 5'd6 || op == 5'd18) begin
        nf = {f[4], nn, zz, ovf, carry};
      end else begin
        res = 32'((dl & ~m) | rm);
      end
    end else if (op <= 5'd15) begin
      case (op)
        5'd7:  r = longint'(d & s);
        5'd8:  r = longint'(d | s);
        5'd9:  r = longint'(d ^ s);
        5'd10: r = longint'(~d);
        5'd11: r = 0;
        5'd12: r = dl;
        5'd13: r = longint'(s);
        5'd14: begin
          if (sz <= 2'd1) begin w = 16; r = as_signed(dl & 255, 8); end
          else begin w = 32; r = as_signed(dl & 65535, 16); end
        end
        default: begin w = 32; r = longint'({d[15:0], d[31:16]}); end
      endcase
      m = (longint'(1) << w) - 1;
      rm = r & m;
      nn = ((rm >> (w - 1)) & 1) != 0;
      zz = (rm == 0);
      res = 32'((dl & ~m) | rm);
      nf = {f[4], nn, zz, 1'b0, 1'b0};
    end
    return {nf, res};
  endfunction

  function automatic string tag_of(logic [4:0] op);
    if (op <= 5'd3) return "R2";
    if (op <= 5'd5) return "R4";
    if (op == 5'd6) return "R5";
    if (op == 5'd11) return "R7";
    if (op <= 5'd13) return "R6";
    if (op == 5'd14) return "R9";
    if (op == 5'd15) return "R10";
    if (op <= 5'd17) return "R11";
    if (op == 5'd18) return "R12";
    return "R13";
  endfunction

  task automatic compare(logic [36:0] exp, string tag);
    checks++;
    if ({flags_o, result_o} !== exp) begin
      errors++;
      $display("FAIL %s: got result=%08h flags=%05b, expected result=%08h flags=%05b",
               tag, result_o, flags_o, exp[31:0], exp[36:32]);
    end
  endtask

  // called at a falling edge; result is due at the next falling edge
  task automatic apply(logic [4:0] op, logic [1:0] sz, logic [31:0] s,
                       logic [31:0] d, logic [4:0] f, string tag);
    logic [36:0] exp;
    en_i = 1'b1; op_i = op; size_i = sz; src_i = s; dst_i = d; flags_i = f;
    exp = model(op, sz, s, d, f);
    @(negedge clk);
    compare(exp, tag);
    last_exp = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected end of test");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; en_i = 1'b0; op_i = '0; size_i = '0;
    src_i = '0; dst_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare(37'd0, "R1 reset");
    en_i = 1'b1; op_i = 5'd13; src_i = 32'hFFFF_FFFF;
    @(negedge clk);
    compare(37'd0, "R1 reset with enable");
    en_i = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 / R8 sized arithmetic corners
    apply(5'd0, 2'd0, 32'h0000_0001, 32'hAABB_CC7F, 5'b00000, "R8 byte add overflow");
    apply(5'd0, 2'd1, 32'h0000_0001, 32'h1234_FFFF, 5'b00000, "R2 word add carry");
    apply(5'd1, 2'd2, 32'h0000_0001, 32'h0000_0000, 5'b00100, "R2 long sub borrow");
    apply(5'd1, 2'd0, 32'h0000_0001, 32'h5555_5580, 5'b00000, "R8 byte sub overflow");
    apply(5'd2, 2'd0, 32'h0000_00FF, 32'h0000_0000, 5'b10000, "R2 add extend carry in");
    // R3 zero chaining
    apply(5'd2, 2'd1, 32'h0, 32'h0, 5'b00100, "R3 add extend zero kept set");
    apply(5'd2, 2'd1, 32'h0, 32'h0, 5'b00000, "R3 add extend zero kept clear");
    apply(5'd3, 2'd0, 32'h1, 32'h2, 5'b10100, "R3 sub extend zero result");
    apply(5'd5, 2'd2, 32'h0, 32'h0, 5'b00100, "R3 negate extend zero");
    // R4
    apply(5'd4, 2'd0, 32'h0, 32'h0000_0080, 5'b00000, "R4 negate most negative");
    apply(5'd4, 2'd1, 32'h0, 32'h0000_0000, 5'b11111, "R4 negate zero");
    apply(5'd5, 2'd0, 32'h0, 32'h0000_0000, 5'b10000, "R4 negate extend");
    // R5 / R12
    apply(5'd6, 2'd0, 32'h0000_0005, 32'hFFFF_FF03, 5'b10000, "R5 compare byte");
    apply(5'd18, 2'd1, 32'h0000_8000, 32'h0000_0001, 5'b00000, "R12 compare sign extended");
    // R6 / R7
    apply(5'd9, 2'd0, 32'h0000_00FF, 32'h1111_11FF, 5'b10011, "R6 xor to zero");
    apply(5'd10, 2'd1, 32'h0, 32'hABCD_0000, 5'b00011, "R6 complement word");
    apply(5'd11, 2'd1, 32'h0, 32'hDEAD_BEEF, 5'b11011, "R7 clear word");
    // R9 / R10
    apply(5'd14, 2'd0, 32'h0, 32'h1234_5680, 5'b10011, "R9 byte to word");
    apply(5'd14, 2'd2, 32'h0, 32'h1234_8000, 5'b00000, "R9 word to long");
    apply(5'd15, 2'd0, 32'h0, 32'h8000_0001, 5'b00000, "R10 swap halves");
    // R11
    apply(5'd16, 2'd1, 32'h0000_FFFF, 32'h0000_0010, 5'b01010, "R11 address add word");
    apply(5'd17, 2'd2, 32'h0000_0001, 32'h0000_0000, 5'b10101, "R11 address sub long");
    // R13
    apply(5'd25, 2'd0, 32'h1234_5678, 32'hCAFE_F00D, 5'b10101, "R13 unused opcode");

    // R1: hold while enable is low
    en_i = 1'b0; op_i = 5'd0; src_i = 32'h1; dst_i = 32'h7; flags_i = 5'b11111;
    @(negedge clk);
    compare(last_exp, "R1 hold idle");
    src_i = 32'h9999_9999;
    @(negedge clk);
    compare(last_exp, "R1 hold idle second");

    // mixed patterns over all opcodes and sizes
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 23));
      apply(op, 2'($urandom_range(0, 3)), $urandom, $urandom,
            5'($urandom_range(0, 31)), tag_of(op));
      if ((i % 97) == 0) begin
        en_i = 1'b0; dst_i = $urandom;
        @(negedge clk);
        compare(last_exp, "R1 hold in sweep");
      end
    end

    // R1: asynchronous reset clears outputs
    rst_n = 1'b0;
    #1;
    compare(37'd0, "R1 asynchronous clear");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule